// File: doc/BRIEF.md
# Paged expanded data RAM

This block holds 768 bytes of on-chip data RAM that an 8052-style core reaches over its external-data access path. Each cycle it takes at most one access request. It works out the 16-bit external-data address, sends the access to the internal array when that address lies in the internal window, and otherwise marks the access as external so that the bus controller runs it on the pins. An access can come from a full 16-bit data pointer or from an 8-bit register-indirect pointer. For the register-indirect case, the upper address byte is filled from a 2-bit page field held in a control register.

Two special-function registers set the block up: a RAM paging register and a system control register. The system control register carries the bit that switches the internal window on. Results are registered. One cycle after a request, the block shows exactly one of three outcomes: internal read data valid, internal write acknowledged, or external access flagged, the last together with the resolved bus address and direction.

The controller is a four-state machine. ST_IDLE means no access was taken in the last cycle. ST_INT_RD means an internal read completed and `rdata` is valid. ST_INT_WR means an internal write completed. ST_EXTERN means the access was handed to the external bus. Every state can go straight to any of the four on each clock, and the choice depends only on the current request. No request leads to ST_IDLE. An address outside the window, or a cleared enable bit, leads to ST_EXTERN. An internal write leads to ST_INT_WR, and an internal read leads to ST_INT_RD.

Top module: `xram_pager`

## Requirements
- R1: After reset the page field is 0, the internal-window enable is 1, and `ext_flag`, `rd_valid`, `wr_ack` and `rdata` are all 0.
- R2: Reading SFR address 0x85 returns the page field in bits 1:0, with bits 7:2 read as 0. Reading 0xBF returns the enable in bit 1, with every other bit read as 0. Any other SFR address reads 0, and a write to it changes neither register.
- R3: With the enable at 1, a data-pointer access to an address from 0x0000 to 0x02FF is served by the array. A read returns the stored byte on `rdata` with `rd_valid` set in the cycle after the request. A write raises `wr_ack` in that same cycle.
- R4: A data-pointer access to 0x0300 or above raises `ext_flag` one cycle after the request. At that point `bus_addr` equals the request address and `bus_we` equals the request's write bit.
- R5: A register-indirect access uses the address page*256 + pointer. Pages 0, 1 and 2 therefore reach 0x0000–0x00FF, 0x0100–0x01FF and 0x0200–0x02FF of the array.
- R6: With page value 3, a register-indirect access is flagged external, and `bus_addr` is 0x0300 + pointer.
- R7: With the enable at 0, every access is flagged external and no array location is written.
- R8: A write to the array finishes within one clock: a read of the same address issued in the very next cycle returns the new byte.
- R9: When both request inputs are high in the same cycle, only the data-pointer access is performed.
- R10: A cycle with no request is followed by a cycle in which `ext_flag`, `rd_valid` and `wr_ack` are all 0. At most one of the three is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for both write and read |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` (combinational) |
| dp_req | input | 1 | Data-pointer access request |
| dp_addr | input | 16 | Data-pointer address |
| ri_req | input | 1 | Register-indirect access request |
| ri_addr | input | 8 | Register-indirect pointer |
| acc_we | input | 1 | 1 = write access, 0 = read access |
| acc_wdata | input | 8 | Write data for the access |
| rdata | output | 8 | Internal read data, 0 unless `rd_valid` |
| rd_valid | output | 1 | Internal read completed |
| wr_ack | output | 1 | Internal write completed |
| ext_flag | output | 1 | Access passed to the external bus |
| bus_addr | output | 16 | Resolved address of the last access |
| bus_we | output | 1 | Direction of the last access |

## Verification
The hardest case to show is that a disabled window leaves the array untouched. While the enable is cleared, the array is not visible from the ports at all. The stimulus first fills the whole window with a computed pattern. It then clears the enable and writes different bytes through both access paths. Finally it sets the enable again and reads those locations back, expecting the original pattern. Paging is covered by sweeping every pointer value on all three internal pages against data written through the data-pointer path, and by separate sweeps of page 3 and of addresses above the window.

// File: rtl/xram_pkg.sv
package xram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_INT_RD = 2'd1,
        ST_INT_WR = 2'd2,
        ST_EXTERN = 2'd3
    } xram_state_t;

    localparam int unsigned XRAM_DEPTH   = 768;
    localparam int unsigned XRAM_AW      = 16;
    localparam int unsigned XRAM_DW      = 8;
    localparam int unsigned XRAM_PAGE_W  = 2;
endpackage

// File: rtl/xram_sfr_regs.sv
module xram_sfr_regs #(
    parameter logic [7:0] ADDR_PAGE   = 8'h85,
    parameter logic [7:0] ADDR_SYSCTL = 8'hBF,
    parameter int unsigned PAGE_W     = 2,
    parameter int unsigned EN_BIT     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    output logic [PAGE_W-1:0] page,
    output logic              en,
    output logic [7:0]        sfr_rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            en   <= 1'b1;
        end else if (sfr_we) begin
            if (sfr_addr == ADDR_PAGE)
                page <= sfr_wdata[PAGE_W-1:0];
            if (sfr_addr == ADDR_SYSCTL)
                en <= sfr_wdata[EN_BIT];
        end
    end

    always_comb begin
        sfr_rdata = '0;
        if (sfr_addr == ADDR_PAGE)
            sfr_rdata[PAGE_W-1:0] = page;
        else if (sfr_addr == ADDR_SYSCTL)
            sfr_rdata[EN_BIT] = en;
    end
endmodule

// File: rtl/xram_decode.sv
module xram_decode #(
    parameter int unsigned DEPTH  = 768,
    parameter int unsigned AW     = 16,
    parameter int unsigned PAGE_W = 2
) (
    input  logic              dp_req,
    input  logic [AW-1:0]     dp_addr,
    input  logic              ri_req,
    input  logic [7:0]        ri_addr,
    input  logic [PAGE_W-1:0] page,
    input  logic              en,
    output logic              req,
    output logic [AW-1:0]     addr,
    output logic              internal
);
    localparam int unsigned PAD_W = AW - 8 - PAGE_W;
    localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

    logic [AW-1:0] ri_full;

    assign ri_full  = {{PAD_W{1'b0}}, page, ri_addr};
    assign req      = dp_req | ri_req;
    // data-pointer request takes precedence
    assign addr     = dp_req ? dp_addr : ri_full;
    assign internal = req && en && (addr < LIMIT);
endmodule

// File: rtl/xram_array.sv
module xram_array #(
    parameter int unsigned DEPTH = 768,
    parameter int unsigned DW    = 8
) (
    input  logic                     clk,
    input  logic                     sel,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            q
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (sel) begin
            if (we)
                mem[idx] <= wdata;
            q <= mem[idx];
        end
    end
endmodule

// File: rtl/xram_pager.sv
module xram_pager
    import xram_pkg::*;
#(
    parameter int unsigned DEPTH  = XRAM_DEPTH,
    parameter int unsigned AW     = XRAM_AW,
    parameter int unsigned DW     = XRAM_DW,
    parameter int unsigned PAGE_W = XRAM_PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sfr_we,
    input  logic [7:0]    sfr_addr,
    input  logic [7:0]    sfr_wdata,
    output logic [7:0]    sfr_rdata,
    input  logic          dp_req,
    input  logic [AW-1:0] dp_addr,
    input  logic          ri_req,
    input  logic [7:0]    ri_addr,
    input  logic          acc_we,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rdata,
    output logic          rd_valid,
    output logic          wr_ack,
    output logic          ext_flag,
    output logic [AW-1:0] bus_addr,
    output logic          bus_we
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [PAGE_W-1:0] page;
    logic              en;
    logic              req;
    logic [AW-1:0]     addr;
    logic              internal;
    logic [DW-1:0]     q;
    xram_state_t       state_q, state_d;

    xram_sfr_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_we    (sfr_we),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .page      (page),
        .en        (en),
        .sfr_rdata (sfr_rdata)
    );

    xram_decode #(.DEPTH(DEPTH), .AW(AW), .PAGE_W(PAGE_W)) u_dec (
        .dp_req   (dp_req),
        .dp_addr  (dp_addr),
        .ri_req   (ri_req),
        .ri_addr  (ri_addr),
        .page     (page),
        .en       (en),
        .req      (req),
        .addr     (addr),
        .internal (internal)
    );

    xram_array #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .sel   (internal),
        .we    (acc_we),
        .idx   (addr[IDX_W-1:0]),
        .wdata (acc_wdata),
        .q     (q)
    );

    always_comb begin
        if (!req)
            state_d = ST_IDLE;
        else if (!internal)
            state_d = ST_EXTERN;
        else if (acc_we)
            state_d = ST_INT_WR;
        else
            state_d = ST_INT_RD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bus_addr <= '0;
            bus_we   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req) begin
                bus_addr <= addr;
                bus_we   <= acc_we;
            end
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        wr_ack   = 1'b0;
        ext_flag = 1'b0;
        rdata    = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_INT_RD: begin
                rd_valid = 1'b1;
                rdata    = q;
            end
            ST_INT_WR: wr_ack   = 1'b1;
            ST_EXTERN: ext_flag = 1'b1;
        endcase
    end
endmodule

// File: rtl/xram_pager_checker.sv
module xram_pager_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        dp_req,
    input logic        ri_req,
    input logic [15:0] dp_addr,
    input logic [7:0]  ri_addr,
    input logic        ext_flag,
    input logic        rd_valid,
    input logic        wr_ack,
    input logic [15:0] bus_addr,
    input logic [7:0]  rdata,
    input logic [1:0]  page,
    input logic        en,
    input logic [7:0]  sfr_addr,
    input logic [7:0]  sfr_rdata
);
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_flag, rd_valid, wr_ack}));

    assert_idle_after_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_req || ri_req) |=> !ext_flag && !rd_valid && !wr_ack);

    assert_high_external_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_req && dp_addr >= 16'h0300) |=> ext_flag && bus_addr == $past(dp_addr));

    assert_page3_external_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_req && !dp_req && page == 2'd3) |=> ext_flag && bus_addr == {8'h03, $past(ri_addr)});

    assert_disabled_external_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dp_req || ri_req) && !en) |=> ext_flag);

    assert_rdata_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rdata == 8'h00);

    assert_page_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == 8'h85 |-> sfr_rdata[7:2] == 6'd0);
endmodule

bind xram_pager xram_pager_checker u_chk (.*);

// File: tb/xram_pager_test.sv
module xram_pager_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        dp_req = 1'b0;
    logic [15:0] dp_addr = 16'h0;
    logic        ri_req = 1'b0;
    logic [7:0]  ri_addr = 8'h0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_wdata = 8'h0;
    logic [7:0]  rdata;
    logic        rd_valid, wr_ack, ext_flag, bus_we;
    logic [15:0] bus_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0]  o_rd;
    logic        o_rv, o_wa, o_ext, o_we;
    logic [15:0] o_ba;

    always #4 clk = ~clk;

    xram_pager uut (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .dp_req(dp_req),
        .dp_addr(dp_addr), .ri_req(ri_req), .ri_addr(ri_addr), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .rdata(rdata), .rd_valid(rd_valid), .wr_ack(wr_ack),
        .ext_flag(ext_flag), .bus_addr(bus_addr), .bus_we(bus_we)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) + ((a >> 8) * 11) + 5);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a;
        #1 d = sfr_rdata;
    endtask

    task automatic access(input bit use_dp, input bit use_ri, input logic [15:0] da,
                          input logic [7:0] ra, input bit we, input logic [7:0] wd);
        @(negedge clk);
        dp_req = use_dp; ri_req = use_ri; dp_addr = da; ri_addr = ra;
        acc_we = we; acc_wdata = wd;
        @(posedge clk);
        #2;
        o_rd = rdata; o_rv = rd_valid; o_wa = wr_ack; o_ext = ext_flag;
        o_ba = bus_addr; o_we = bus_we;
        dp_req = 1'b0; ri_req = 1'b0; acc_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        #20 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ext_flag", 32'(ext_flag), 0);
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 wr_ack", 32'(wr_ack), 0);
        check("R1 rdata", 32'(rdata), 0);
        sfr_read(8'h85, r); check("R1 page reset", 32'(r), 32'h00);
        sfr_read(8'hBF, r); check("R1 enable reset", 32'(r), 32'h02);

        // R2 register access
        sfr_write(8'h85, 8'hFE);
        sfr_read(8'h85, r); check("R2 page field", 32'(r), 32'h02);
        sfr_write(8'h85, 8'hFF);
        sfr_read(8'h85, r); check("R2 page unused bits", 32'(r), 32'h03);
        sfr_write(8'hBF, 8'hFD);
        sfr_read(8'hBF, r); check("R2 enable clear", 32'(r), 32'h00);
        sfr_write(8'hBF, 8'hFF);
        sfr_read(8'hBF, r); check("R2 enable set", 32'(r), 32'h02);
        sfr_write(8'h84, 8'h00);
        sfr_write(8'hBE, 8'h00);
        sfr_read(8'h84, r); check("R2 other addr reads 0", 32'(r), 0);
        sfr_read(8'h85, r); check("R2 page unchanged", 32'(r), 32'h03);
        sfr_read(8'hBF, r); check("R2 enable unchanged", 32'(r), 32'h02);
        sfr_write(8'h85, 8'h00);

        // R3 fill and read back whole window via data pointer
        for (int a = 0; a < 768; a++) begin
            access(1, 0, 16'(a), 8'h00, 1, pat(a));
            check("R3 write ack", 32'({o_wa, o_ext, o_rv}), 32'b100);
        end
        for (int a = 0; a < 768; a++) begin
            access(1, 0, 16'(a), 8'h00, 0, 8'h00);
            check("R3 read data", 32'({o_rv, o_ext, o_rd}), 32'({2'b10, pat(a)}));
        end

        // R10 idle cycle
        @(posedge clk); #2;
        check("R10 idle outputs", 32'({ext_flag, rd_valid, wr_ack}), 0);

        // R5 paging sweep
        for (int p = 0; p < 3; p++) begin
            sfr_write(8'h85, 8'(p));
            for (int a = 0; a < 256; a++) begin
                access(0, 1, 16'h0, 8'(a), 0, 8'h00);
                check("R5 paged read", 32'({o_rv, o_rd}), 32'({1'b1, pat(p * 256 + a)}));
            end
        end
        sfr_write(8'h85, 8'h01);
        access(0, 1, 16'h0, 8'h33, 1, 8'hC3);
        check("R5 paged write ack", 32'(o_wa), 1);
        access(1, 0, 16'h0133, 8'h00, 0, 8'h00);
        check("R5 paged write lands at 0x133", 32'(o_rd), 32'hC3);

        // R8 write then immediate read
        access(1, 0, 16'h02AA, 8'h00, 1, 8'h5E);
        access(1, 0, 16'h02AA, 8'h00, 0, 8'h00);
        check("R8 back-to-back read", 32'({o_rv, o_rd}), 32'h15E);

        // R6 page 3
        sfr_write(8'h85, 8'h03);
        for (int a = 0; a < 256; a += 17) begin
            access(0, 1, 16'h0, 8'(a), (a & 1) != 0, 8'h11);
            check("R6 page3 external", 32'({o_ext, o_rv, o_wa, o_we, o_ba}),
                  32'({1'b1, 1'b0, 1'b0, 1'((a & 1) != 0), 16'h0300 + 16'(a)}));
        end

        // R4 high data-pointer addresses
        for (int a = 16'h0300; a < 32'h10000; a += 16'h0F3D) begin
            access(1, 0, 16'(a), 8'h00, 1, 8'h77);
            check("R4 high external", 32'({o_ext, o_wa, o_we, o_ba}), 32'({3'b101, 16'(a)}));
        end
        access(1, 0, 16'hFFFF, 8'h00, 0, 8'h00);
        check("R4 top address", 32'({o_ext, o_rv, o_we, o_ba}), 32'({3'b100, 16'hFFFF}));
        access(1, 0, 16'h02FF, 8'h00, 0, 8'h00);
        check("R4 last internal byte", 32'({o_ext, o_rv, o_rd}), 32'({2'b01, pat(16'h2FF)}));

        // R9 both requests
        sfr_write(8'h85, 8'h01);
        access(1, 1, 16'h0005, 8'h05, 0, 8'h00);
        check("R9 dp wins read", 32'({o_rv, o_rd}), 32'({1'b1, pat(5)}));
        access(1, 1, 16'h0400, 8'h07, 0, 8'h00);
        check("R9 dp wins external", 32'({o_ext, o_ba}), 32'({1'b1, 16'h0400}));
        access(1, 1, 16'h0006, 8'h06, 1, 8'h9A);
        access(1, 0, 16'h0106, 8'h00, 0, 8'h00);
        check("R9 ri side untouched", 32'(o_rd), 32'(pat(16'h106)));
        access(1, 0, 16'h0006, 8'h00, 0, 8'h00);
        check("R9 dp side written", 32'(o_rd), 32'h9A);

        // R7 disabled window
        sfr_write(8'hBF, 8'h00);
        sfr_write(8'h85, 8'h00);
        access(1, 0, 16'h0010, 8'h00, 1, ~pat(16'h10));
        check("R7 dp external", 32'({o_ext, o_wa, o_we, o_ba}), 32'({3'b101, 16'h0010}));
        access(0, 1, 16'h0, 8'h20, 1, ~pat(16'h20));
        check("R7 ri external", 32'({o_ext, o_wa, o_ba}), 32'({2'b10, 16'h0020}));
        access(1, 0, 16'h0030, 8'h00, 0, 8'h00);
        check("R7 read external", 32'({o_ext, o_rv, o_rd}), 32'({2'b10, 8'h00}));
        sfr_write(8'hBF, 8'h02);
        access(1, 0, 16'h0010, 8'h00, 0, 8'h00);
        check("R7 array kept 0x10", 32'(o_rd), 32'(pat(16'h10)));
        access(1, 0, 16'h0020, 8'h00, 0, 8'h00);
        check("R7 array kept 0x20", 32'(o_rd), 32'(pat(16'h20)));

        @(posedge clk); #2;
        check("R10 final idle", 32'({ext_flag, rd_valid, wr_ack}), 0);
        done = 1'b1;
        finish_run();
    end
endmodule